// File: doc/BRIEF.md
# Auto-Increment I2C Register Target

This block is an I2C target that gives a bus master read and write access to a bank of byte-wide registers with byte addresses. SCL and SDA are sampled in the fast system clock domain and pass through a synchronizer with edge detection. Bus START and STOP conditions are recovered from the synchronized lines. The only output toward the bus is an open-drain pull-down enable for SDA. Toward the register file the block offers a simple port: an address, a write-data byte, a one-cycle write strobe, and a combinational read-data input.

A transaction opens with a START and a device-address byte. Its seven upper bits are compared against one of three device addresses, picked by a two-bit strap code that encodes a pin tied low, left open or tied high. On a write, the first byte after the device address loads the register pointer and every later byte is written at the pointer. On a read, the target returns the register at the pointer. In both directions the pointer steps by one after each data byte. The pointer survives STOP and repeated START, so a random read is done as a pointer write, a repeated START, then a read. Clock stretching, 10-bit addressing and general call are not supported.

Top module: `i2c_regbank_target`

## Requirements
- R1: After reset, SDA is released (sda_oe = 0), no write strobe is issued, and the register pointer is 0x00.
- R2: SDA falling while SCL is high (START) always restarts device-address reception, even in the middle of a byte. SDA rising while SCL is high (STOP) returns the target to idle.
- R3: The device-address byte is sent MSB first: seven address bits, then the R/W bit in bit 0 (0 = write, 1 = read). Strap code 2'b00 (tied low) selects 0x65. Code 2'b01 (open) selects 0x66, which gives wire bytes 0xCC for write and 0xCD for read. Code 2'b10 (tied high) selects 0x67. The unused code 2'b11 falls back to 0x66.
- R4: The target pulls SDA low through the ninth SCL clock of a matching device-address byte, of the register-address byte, and of every write data byte.
- R5: A device address that does not match gets no acknowledge. Every later byte is then ignored, with no acknowledge and no register write, until the next START.
- R6: In a write, the byte after the device address loads the pointer. Each later byte produces one write of that byte at the pointer, and the pointer then steps by one, wrapping from 0xFF to 0x00.
- R7: In a read, the target shifts out the register at the pointer MSB first, and the pointer steps by one after each byte. A master ACK (SDA low on the ninth clock) starts the next byte. A master NACK leaves SDA released and the target idle.
- R8: The pointer is kept across STOP, across repeated START, and across a transaction aborted part-way through a byte. A read with no preceding pointer write starts at the kept value.
- R9: The write strobe is exactly one system-clock cycle wide, once per acknowledged write data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (wired level) |
| addr_sel | input | 2 | Strap code selecting the device address |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | REG_AW | Register pointer, used for both reads and writes |
| reg_wdata | output | REG_DW | Data for the register write |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | REG_DW | Register contents at reg_addr, combinational |

## Verification
The bench sweeps sixteen device addresses around the match window for every strap code. A decoder that uses the wrong bits or maps a strap code to the wrong value acknowledges the wrong byte or stays silent. Bursts start near 0xFF so that a pointer that fails to wrap, or that steps at the wrong moment, writes to or reads from the wrong register. A STOP in the middle of a byte must leave the pointer and the registers untouched. A mismatched address followed by data bytes must draw neither an acknowledge nor a write strobe. A master NACK must end the read with SDA released: a design that kept driving the bus would corrupt the STOP that follows.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK
   } tgt_state_t;

   typedef enum logic [1:0] {
      K_DEV,
      K_REG,
      K_DATA
   } rx_kind_t;

   typedef struct packed {
      logic scl;
      logic sda;
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
   } bus_ev_t;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync
   import i2c_tgt_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_i,
   input  logic    sda_i,
   output bus_ev_t ev
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_bus_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_q;
   logic              sda_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_pipe[i] <= 1'b1;
            sda_pipe[i] <= 1'b1;
         end else if (i == 0) begin
            scl_pipe[i] <= scl_i;
            sda_pipe[i] <= sda_i;
         end else begin
            scl_pipe[i] <= scl_pipe[(i == 0) ? 0 : i-1];
            sda_pipe[i] <= sda_pipe[(i == 0) ? 0 : i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_pipe[STAGES-1];
         sda_q <= sda_pipe[STAGES-1];
      end
   end

   always_comb begin
      ev.scl      = scl_pipe[STAGES-1];
      ev.sda      = sda_pipe[STAGES-1];
      ev.scl_rise = ev.scl & ~scl_q;
      ev.scl_fall = ~ev.scl & scl_q;
      ev.start    = scl_q & ev.scl & sda_q & ~ev.sda;
      ev.stop     = scl_q & ev.scl & ~sda_q & ev.sda;
   end

endmodule

// File: rtl/i2c_strap_decode.sv
module i2c_strap_decode #(
   parameter logic [6:0] ADDR_LOW  = 7'h65,
   parameter logic [6:0] ADDR_OPEN = 7'h66,
   parameter logic [6:0] ADDR_HIGH = 7'h67
) (
   input  logic [1:0] sel,
   output logic [6:0] dev_addr
);

   if (ADDR_LOW == ADDR_OPEN || ADDR_OPEN == ADDR_HIGH || ADDR_LOW == ADDR_HIGH) begin : g_bad_map
      $error("i2c_strap_decode: strap addresses must differ");
   end

   always_comb begin
      unique case (sel)
         2'b00:   dev_addr = ADDR_LOW;
         2'b10:   dev_addr = ADDR_HIGH;
         default: dev_addr = ADDR_OPEN;
      endcase
   end

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
   import i2c_tgt_pkg::*;
#(
   parameter int         REG_AW      = 8,
   parameter int         REG_DW      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] ADDR_LOW    = 7'h65,
   parameter logic [6:0] ADDR_OPEN   = 7'h66,
   parameter logic [6:0] ADDR_HIGH   = 7'h67
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [1:0]        addr_sel,
   output logic              sda_oe,
   output logic [REG_AW-1:0] reg_addr,
   output logic [REG_DW-1:0] reg_wdata,
   output logic              reg_we,
   input  logic [REG_DW-1:0] reg_rdata
);

   localparam int BYTE_W = 8;
   localparam int CNT_W  = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   if (REG_DW != BYTE_W || REG_AW != BYTE_W) begin : g_bad_width
      $error("i2c_regbank_target: register address and data must be one byte");
   end

   bus_ev_t           ev;
   logic [6:0]        dev_addr;
   tgt_state_t        state;
   rx_kind_t          kind;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] rx_sh;
   logic [BYTE_W-1:0] tx_sh;
   logic [REG_AW-1:0] ptr;
   logic              rw;
   logic              mnack;

   i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .ev    (ev)
   );

   i2c_strap_decode #(
      .ADDR_LOW  (ADDR_LOW),
      .ADDR_OPEN (ADDR_OPEN),
      .ADDR_HIGH (ADDR_HIGH)
   ) u_strap (
      .sel      (addr_sel),
      .dev_addr (dev_addr)
   );

   assign reg_addr = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         kind      <= K_DEV;
         cnt       <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         ptr       <= '0;
         rw        <= 1'b0;
         mnack     <= 1'b0;
         sda_oe    <= 1'b0;
         reg_we    <= 1'b0;
         reg_wdata <= '0;
      end else begin
         reg_we <= 1'b0;
         if (ev.start) begin
            state  <= ST_RX;
            kind   <= K_DEV;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (ev.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_RX: begin
                  if (ev.scl_rise) begin
                     rx_sh <= {rx_sh[BYTE_W-2:0], ev.sda};
                     cnt   <= cnt + 1'b1;
                  end else if (ev.scl_fall && cnt == LAST_BIT) begin
                     cnt <= '0;
                     unique case (kind)
                        K_DEV: begin
                           if (rx_sh[BYTE_W-1:1] == dev_addr) begin
                              rw     <= rx_sh[0];
                              sda_oe <= 1'b1;
                              state  <= ST_RX_ACK;
                           end else begin
                              state  <= ST_IDLE;
                           end
                        end
                        K_REG: begin
                           ptr    <= rx_sh;
                           sda_oe <= 1'b1;
                           state  <= ST_RX_ACK;
                        end
                        default: begin
                           reg_wdata <= rx_sh;
                           reg_we    <= 1'b1;
                           sda_oe    <= 1'b1;
                           state     <= ST_RX_ACK;
                        end
                     endcase
                  end
               end
               ST_RX_ACK: begin
                  if (ev.scl_fall) begin
                     sda_oe <= 1'b0;
                     state  <= ST_RX;
                     if (kind == K_DEV && rw) begin
                        tx_sh  <= reg_rdata;
                        sda_oe <= ~reg_rdata[BYTE_W-1];
                        state  <= ST_TX;
                     end else if (kind == K_DEV) begin
                        kind <= K_REG;
                     end else if (kind == K_REG) begin
                        kind <= K_DATA;
                     end else begin
                        ptr <= ptr + 1'b1;
                     end
                  end
               end
               ST_TX: begin
                  if (ev.scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (ev.scl_fall) begin
                     if (cnt == LAST_BIT) begin
                        sda_oe <= 1'b0;
                        state  <= ST_TX_ACK;
                     end else begin
                        tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~tx_sh[BYTE_W-2];
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (ev.scl_rise) begin
                     mnack <= ev.sda;
                     ptr   <= ptr + 1'b1;
                  end else if (ev.scl_fall) begin
                     cnt <= '0;
                     if (mnack) begin
                        state <= ST_IDLE;
                     end else begin
                        tx_sh  <= reg_rdata;
                        sda_oe <= ~reg_rdata[BYTE_W-1];
                        state  <= ST_TX;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_regbank_target_chk.sv
module i2c_regbank_target_chk
   import i2c_tgt_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       start_det,
   input logic       stop_det,
   input tgt_state_t state,
   input rx_kind_t   kind,
   input logic       sda_oe,
   input logic       reg_we
);

   a_r2_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_RX && kind == K_DEV));

   a_r2_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE));

   a_r5_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   a_r7_master_ack_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TX_ACK) |-> !sda_oe);

   a_r6_we_only_data: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (kind == K_DATA && state == ST_RX_ACK && sda_oe));

   a_r9_we_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

endmodule

bind i2c_regbank_target i2c_regbank_target_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_det (ev.start),
   .stop_det  (ev.stop),
   .state     (state),
   .kind      (kind),
   .sda_oe    (sda_oe),
   .reg_we    (reg_we)
);

// File: tb/test_i2c_regbank_target.sv
module test_i2c_regbank_target;

   localparam int Q = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic [1:0] addr_sel = 2'b01;
   logic       sda_oe;
   logic [7:0] reg_addr;
   logic [7:0] reg_wdata;
   logic       reg_we;
   logic [7:0] reg_rdata;
   logic       sda_line;

   logic [7:0] mem [256];
   logic [7:0] exp_mem [256];
   int checks = 0;
   int failures = 0;
   int we_count = 0;
   int cycles = 0;
   bit done = 0;

   always #2 clk = ~clk;

   assign sda_line  = sda_m & ~sda_oe;
   assign reg_rdata = mem[reg_addr];

   i2c_regbank_target i_i2c_regbank_target (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl),
      .sda_i     (sda_line),
      .addr_sel  (addr_sel),
      .sda_oe    (sda_oe),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_rdata (reg_rdata)
   );

   always @(posedge clk) begin
      if (reg_we) begin
         mem[reg_addr] <= reg_wdata;
         we_count <= we_count + 1;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq();
      scl = 1'b1;   wq();
      sda_m = 1'b0; wq();
      scl = 1'b0;   wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq();
      scl = 1'b1;   wq();
      sda_m = 1'b1; wq();
   endtask

   task automatic send_bit(input logic b);
      sda_m = b;  wq();
      scl = 1'b1; wq();
      wq();
      scl = 1'b0; wq();
   endtask

   task automatic recv_bit(output logic b);
      sda_m = 1'b1; wq();
      scl = 1'b1;   wq();
      b = sda_line; wq();
      scl = 1'b0;   wq();
   endtask

   task automatic write_byte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(b);
      ack = ~b;
   endtask

   task automatic read_byte(input logic mack, output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         d[i] = b;
      end
      send_bit(~mack);
   endtask

   function automatic logic [6:0] strap_addr(input logic [1:0] s);
      return (s == 2'b00) ? 7'h65 : (s == 2'b10) ? 7'h67 : 7'h66;
   endfunction

   initial begin
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      logic ack;
      logic [7:0] d;
      int wc;
      for (int i = 0; i < 256; i++) begin
         mem[i] = 8'(i ^ 8'hA5);
         exp_mem[i] = 8'(i ^ 8'hA5);
      end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1: reset state at the ports
      check("R1 sda_oe", int'(sda_oe), 0);
      check("R1 reg_we", int'(reg_we), 0);
      check("R1 pointer", int'(reg_addr), 0);

      // R3/R4: sweep of addresses around the window for each strap code
      for (int s = 0; s < 4; s++) begin
         addr_sel = 2'(s);
         for (int a = 8'h60; a < 8'h70; a++) begin
            bus_start();
            write_byte({7'(a), 1'b0}, ack);
            bus_stop();
            check($sformatf("R3 R4 strap=%0d addr=0x%0h ack", s, a), int'(ack),
                  int'(7'(a) == strap_addr(2'(s))));
         end
      end
      check("R5 R9 no strobe in sweep", we_count, 0);

      addr_sel = 2'b01;
      // R6: burst write across the 0xFF wrap
      wc = we_count;
      bus_start();
      write_byte(8'hCC, ack); check("R4 dev ack", int'(ack), 1);
      write_byte(8'hFD, ack); check("R4 reg ack", int'(ack), 1);
      for (int i = 0; i < 4; i++) begin
         d = 8'(i * 8'h37 + 5);
         exp_mem[8'(8'hFD + i)] = d;
         write_byte(d, ack);
         check($sformatf("R4 data ack %0d", i), int'(ack), 1);
      end
      bus_stop();
      check("R9 one strobe per byte", we_count - wc, 4);
      for (int i = 0; i < 4; i++)
         check($sformatf("R6 wrap write reg 0x%0h", 8'(8'hFD + i)),
               int'(mem[8'(8'hFD + i)]), int'(exp_mem[8'(8'hFD + i)]));

      // R7/R8: random read through repeated START, ACK then NACK
      bus_start();
      write_byte(8'hCC, ack);
      write_byte(8'hFD, ack);
      bus_start();
      write_byte(8'hCD, ack); check("R3 read addr ack", int'(ack), 1);
      for (int i = 0; i < 4; i++) begin
         read_byte(i != 3, d);
         check($sformatf("R7 R8 read reg 0x%0h", 8'(8'hFD + i)), int'(d),
               int'(exp_mem[8'(8'hFD + i)]));
      end
      check("R7 released after NACK", int'(sda_oe), 0);
      bus_stop();
      check("R7 pointer after read", int'(reg_addr), 8'h01);

      // R8: current-address read starts at kept pointer
      bus_start();
      write_byte(8'hCD, ack);
      read_byte(1'b0, d);
      bus_stop();
      check("R8 current address read", int'(d), int'(exp_mem[1]));

      // R5: mismatch then data bytes are ignored
      wc = we_count;
      bus_start();
      write_byte(8'hCA, ack); check("R5 mismatch no ack", int'(ack), 0);
      write_byte(8'h10, ack); check("R5 later byte no ack", int'(ack), 0);
      write_byte(8'h55, ack); check("R5 later byte no ack 2", int'(ack), 0);
      bus_stop();
      check("R5 no write on mismatch", we_count - wc, 0);
      check("R5 reg 0x10 untouched", int'(mem[8'h10]), int'(exp_mem[8'h10]));

      // R2/R8: STOP part-way through a data byte
      wc = we_count;
      bus_start();
      write_byte(8'hCC, ack);
      write_byte(8'h20, ack);
      for (int i = 0; i < 4; i++) send_bit(1'b0);
      bus_stop();
      check("R2 aborted byte no write", we_count - wc, 0);
      check("R2 idle after stop", int'(sda_oe), 0);
      bus_start();
      write_byte(8'hCD, ack);
      read_byte(1'b0, d);
      bus_stop();
      check("R8 pointer kept over abort", int'(d), int'(exp_mem[8'h20]));

      // R2: START in the middle of a byte restarts address reception
      bus_start();
      write_byte(8'hCC, ack);
      for (int i = 0; i < 3; i++) send_bit(1'b1);
      bus_start();
      write_byte(8'hCC, ack); check("R2 restart mid-byte ack", int'(ack), 1);
      bus_stop();

      // R6/R7: long wrapping burst write and burst read back
      wc = we_count;
      bus_start();
      write_byte(8'hCC, ack);
      write_byte(8'hE0, ack);
      for (int i = 0; i < 64; i++) begin
         d = 8'(i * 8'h1D + 8'h3C);
         exp_mem[8'(8'hE0 + i)] = d;
         write_byte(d, ack);
      end
      bus_stop();
      check("R9 burst strobes", we_count - wc, 64);
      bus_start();
      write_byte(8'hCC, ack);
      write_byte(8'hE0, ack);
      bus_start();
      write_byte(8'hCD, ack);
      for (int i = 0; i < 64; i++) begin
         read_byte(i != 63, d);
         check($sformatf("R6 R7 burst reg 0x%0h", 8'(8'hE0 + i)), int'(d),
               int'(exp_mem[8'(8'hE0 + i)]));
      end
      bus_stop();
      check("R7 pointer after burst", int'(reg_addr), 8'h20);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule